// File: doc/BRIEF.md
# Split-Aware Bus Master Arbiter

This block decides which of up to sixteen masters may drive a pipelined system bus. Each master brings a request line and a lock line. The arbiter answers with a one-hot grant vector, a 4-bit index of the master that currently owns the address phase, and a flag that marks the owner's transfers as locked. Slot 0 is reserved for a dummy master that only ever issues IDLE. One real master is chosen by parameter as the default master. It takes the bus when nobody asks for it.

The arbiter watches the shared ready line, the two-bit slave response, the transfer type and the burst type of the current owner. A slave that answers SPLIT causes the master of that data phase to be masked out of arbitration. The master stays masked until the slave raises that master's bit on a 16-bit release vector. If the split master was inside a locked sequence, the bus is parked on the dummy master until that master is released. Fixed-length bursts keep the bus without the master having to hold its request. A locked master keeps the bus as long as its lock line stays high.

Top module: `mbus_arbiter`

## Requirements
- R1: After reset, the grant points at DEFAULT_MASTER, the owner index equals DEFAULT_MASTER, and the lock flag is low.
- R2: Exactly one grant bit is high at all times. The owner index takes the granted index only at a clock edge where ready is high, and it is unchanged across any edge where ready is low.
- R3: Among the masters 1..NUM_MASTERS-1 that request and are not masked, the lowest index wins. The request bit of slot 0 is ignored.
- R4: With no request from masters 1..NUM_MASTERS-1, the grant goes to DEFAULT_MASTER, or to index 0 if the default master is currently split-masked.
- R5: At a ready edge where ownership passes to a newly granted master, the grant is not re-evaluated, so the new owner holds the grant for at least one more cycle.
- R6: When the owner issues NONSEQ (transfer type 2'b10) with a fixed-length burst type, the grant stays with it until only its final beat remains. Burst type 3'b010/3'b011 means 4 beats, 3'b100/3'b101 means 8 beats, and 3'b110/3'b111 means 16 beats. SEQ is 2'b11, BUSY 2'b01 and IDLE 2'b00. Any other burst type, including 3'b001 (undefined length), gives no hold.
- R7: In the first response cycle of a SPLIT (response 2'b11 while ready is low), the master of the current data phase is masked and the grant is re-evaluated in that same cycle.
- R8: A masked master is never granted until bit i of the release vector is seen high. Master 0 is never masked.
- R9: If masters request but every one of them is masked, the grant goes to dummy index 0.
- R10: While the granted master holds its lock line high and is also the owner, no other master is granted. The lock flag is high for the address phases of a master that was granted with its lock line high.
- R11: A SPLIT whose data phase was locked parks the grant on index 0 until the split master is released, whatever the other requests are.
- R12: RETRY (2'b10) and ERROR (2'b01) first cycles re-evaluate the grant but mask nobody.
- R13: In a cycle with ready low and response OKAY (2'b00), the grant does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_MASTERS | Per-master bus request; bit 0 ignored |
| lock_i | input | NUM_MASTERS | Per-master lock request |
| ready_i | input | 1 | Shared transfer-done line |
| resp_i | input | 2 | Slave response: OKAY 00, ERROR 01, RETRY 10, SPLIT 11 |
| trans_i | input | 2 | Owner's transfer type: IDLE 00, BUSY 01, NONSEQ 10, SEQ 11 |
| burst_i | input | 3 | Owner's burst type |
| split_release_i | input | 16 | Per-master release from slaves; bits at or above NUM_MASTERS unused |
| grant_o | output | NUM_MASTERS | One-hot grant |
| owner_o | output | 4 | Index of current address-phase owner |
| owner_lock_o | output | 1 | Owner's transfers are locked |

## Verification
The bench builds the arbiter with NUM_MASTERS = 6 and DEFAULT_MASTER = 3. This small master count means random traffic often reaches the case where every requester is split, hits the default master while it is itself masked, and produces locked splits that park the bus. The release vector then carries stray bits above the master count. A behavioural model of the grant, owner and lock outputs runs next to the design. Directed sequences walk through a 4-beat burst handover, a split with late release, a locked split and a retry before thousands of random cycles.

// File: rtl/mbarb_pkg.sv
package mbarb_pkg;

   localparam int IDX_W   = 4;
   localparam int REL_W   = 16;
   localparam int MAX_MST = 16;

   typedef enum logic [1:0] {
      TR_IDLE = 2'b00,
      TR_BUSY = 2'b01,
      TR_NSEQ = 2'b10,
      TR_SEQ  = 2'b11
   } trans_e;

   localparam logic [1:0] RSP_OKAY  = 2'b00;
   localparam logic [1:0] RSP_ERROR = 2'b01;
   localparam logic [1:0] RSP_RETRY = 2'b10;
   localparam logic [1:0] RSP_SPLIT = 2'b11;

   // number of beats of a fixed-length burst, 0 for single/undefined
   function automatic logic [4:0] burst_beats(input logic [2:0] btype);
      logic [4:0] n;
      unique case (btype)
         3'b010, 3'b011: n = 5'd4;
         3'b100, 3'b101: n = 5'd8;
         3'b110, 3'b111: n = 5'd16;
         default:        n = 5'd0;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/mbarb_pick.sv
module mbarb_pick #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     elig_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);

   logic [N:0]   seen;
   logic [N-1:0] first_hit;

   assign seen[0] = 1'b0;

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_chain
         assign seen[gi+1]    = seen[gi] | elig_i[gi];
         assign first_hit[gi] = elig_i[gi] & ~seen[gi];
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (first_hit[i]) idx_o = idx_o | IDX_W'(i);
      end
   end

   assign found_o = seen[N];

endmodule

// File: rtl/mbarb_burst_track.sv
module mbarb_burst_track
   import mbarb_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ready_i,
   input  logic             first_i,
   input  logic [1:0]       trans_i,
   input  logic [2:0]       burst_i,
   output logic [CNT_W-1:0] rem_next_o
);

   generate
      if (CNT_W < 5) begin : g_bad_cnt
         $error("mbarb_burst_track: CNT_W must hold 15");
      end
   endgenerate

   logic [CNT_W-1:0] rem_q;
   logic [4:0]       beats;

   assign beats = burst_beats(burst_i);

   always_comb begin
      rem_next_o = rem_q;
      if (first_i) begin
         rem_next_o = '0;
      end else if (ready_i) begin
         unique case (trans_e'(trans_i))
            TR_NSEQ: rem_next_o = (beats != 5'd0) ? CNT_W'(beats - 5'd1) : '0;
            TR_SEQ:  rem_next_o = (rem_q != '0) ? rem_q - CNT_W'(1) : '0;
            TR_IDLE: rem_next_o = '0;
            default: rem_next_o = rem_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rem_q <= '0;
      else        rem_q <= rem_next_o;
   end

endmodule

// File: rtl/mbarb_split_track.sv
module mbarb_split_track #(
   parameter int N     = 16,
   parameter int REL_W = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             split_ev_i,
   input  logic [IDX_W-1:0] split_idx_i,
   input  logic             split_locked_i,
   input  logic [REL_W-1:0] release_i,
   output logic [N-1:0]     mask_q_o,
   output logic [N-1:0]     mask_next_o,
   output logic             park_q_o,
   output logic             park_next_o
);

   localparam logic [N-1:0] ONE = N'(1);

   generate
      if (REL_W < N) begin : g_bad_rel
         $error("mbarb_split_track: release vector narrower than master count");
      end
   endgenerate

   logic [N-1:0]     set_oh;
   logic [N-1:0]     pidx_oh;
   logic [IDX_W-1:0] pidx_q;

   assign set_oh  = split_ev_i ? (ONE << split_idx_i) : '0;
   assign pidx_oh = ONE << pidx_q;

   genvar gb;
   generate
      for (gb = 0; gb < N; gb++) begin : g_mask
         if (gb == 0) begin : g_dummy
            assign mask_next_o[gb] = 1'b0;
         end else begin : g_real
            assign mask_next_o[gb] = (mask_q_o[gb] & ~release_i[gb]) | set_oh[gb];
         end
      end
   endgenerate

   always_comb begin
      park_next_o = park_q_o;
      if (split_ev_i && split_locked_i)             park_next_o = 1'b1;
      else if (park_q_o && !(|(mask_next_o & pidx_oh))) park_next_o = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q_o <= '0;
         park_q_o <= 1'b0;
         pidx_q   <= '0;
      end else begin
         mask_q_o <= mask_next_o;
         park_q_o <= park_next_o;
         if (split_ev_i && split_locked_i) pidx_q <= split_idx_i;
      end
   end

   AST_PARKED_MASTER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      park_q_o |-> (|(mask_q_o & pidx_oh))) else $error("parked without masked master"); // R11

endmodule

// File: rtl/mbus_arbiter.sv
module mbus_arbiter
   import mbarb_pkg::*;
#(
   parameter int NUM_MASTERS    = 16,
   parameter int DEFAULT_MASTER = 1,
   parameter int HOLD_CNT_W     = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_MASTERS-1:0] req_i,
   input  logic [NUM_MASTERS-1:0] lock_i,
   input  logic                   ready_i,
   input  logic [1:0]             resp_i,
   input  logic [1:0]             trans_i,
   input  logic [2:0]             burst_i,
   input  logic [15:0]            split_release_i,
   output logic [NUM_MASTERS-1:0] grant_o,
   output logic [3:0]             owner_o,
   output logic                   owner_lock_o
);

   localparam int N = NUM_MASTERS;
   localparam logic [N-1:0]     ONE     = N'(1);
   localparam logic [N-1:0]     DEF_OH  = ONE << DEFAULT_MASTER;
   localparam logic [IDX_W-1:0] DEF_IDX = IDX_W'(DEFAULT_MASTER);
   localparam logic [IDX_W-1:0] DUMMY   = '0;

   generate
      if (N < 2 || N > MAX_MST) begin : g_bad_n
         $error("mbus_arbiter: NUM_MASTERS out of range");
      end
      if (DEFAULT_MASTER < 1 || DEFAULT_MASTER >= N) begin : g_bad_def
         $error("mbus_arbiter: DEFAULT_MASTER must be a real master");
      end
   endgenerate

   logic [IDX_W-1:0] grant_q, grant_next, owner_q, downer_q;
   logic             olock_q, dlock_q;
   logic             first_cyc, split_ev;
   logic [N-1:0]     mask_q, mask_next;
   logic             park_q, park_next;
   logic [HOLD_CNT_W-1:0] rem_next;
   logic [N-1:0]     grant_oh, owner_oh, elig;
   logic             pick_found;
   logic [IDX_W-1:0] pick_idx;
   logic             settle, hold, keep_lock, any_req, grant_locked;

   assign first_cyc = (resp_i != RSP_OKAY) && !ready_i;
   assign split_ev  = first_cyc && (resp_i == RSP_SPLIT) && (downer_q != DUMMY);

   mbarb_split_track #(.N(N), .REL_W(REL_W), .IDX_W(IDX_W)) split_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .split_ev_i     (split_ev),
      .split_idx_i    (downer_q),
      .split_locked_i (dlock_q),
      .release_i      (split_release_i),
      .mask_q_o       (mask_q),
      .mask_next_o    (mask_next),
      .park_q_o       (park_q),
      .park_next_o    (park_next)
   );

   mbarb_burst_track #(.CNT_W(HOLD_CNT_W)) burst_i_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .ready_i    (ready_i),
      .first_i    (first_cyc),
      .trans_i    (trans_i),
      .burst_i    (burst_i),
      .rem_next_o (rem_next)
   );

   assign grant_oh = ONE << grant_q;
   assign owner_oh = ONE << owner_q;
   assign elig     = req_i & ~mask_next & ~ONE;
   assign any_req  = |(req_i & ~ONE);

   mbarb_pick #(.N(N), .IDX_W(IDX_W)) pick_i (
      .elig_i  (elig),
      .found_o (pick_found),
      .idx_o   (pick_idx)
   );

   assign grant_locked = (grant_q != DUMMY) && (|(lock_i & grant_oh));
   assign settle    = ready_i && (grant_q != owner_q);
   assign hold      = ready_i && (rem_next >= HOLD_CNT_W'(2)) && !(|(mask_next & owner_oh));
   assign keep_lock = grant_locked && !(|(mask_next & grant_oh));

   always_comb begin
      grant_next = grant_q;
      if (ready_i || first_cyc) begin
         if (park_next)                      grant_next = DUMMY;
         else if (settle)                    grant_next = grant_q;
         else if (hold)                      grant_next = owner_q;
         else if (keep_lock)                 grant_next = grant_q;
         else if (pick_found)                grant_next = pick_idx;
         else if (any_req)                   grant_next = DUMMY;
         else if (|(mask_next & DEF_OH))     grant_next = DUMMY;
         else                                grant_next = DEF_IDX;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q  <= DEF_IDX;
         owner_q  <= DEF_IDX;
         downer_q <= DUMMY;
         olock_q  <= 1'b0;
         dlock_q  <= 1'b0;
      end else begin
         grant_q <= grant_next;
         if (ready_i) begin
            owner_q  <= grant_q;
            olock_q  <= grant_locked;
            downer_q <= owner_q;
            dlock_q  <= olock_q;
         end
      end
   end

   assign grant_o      = grant_oh;
   assign owner_o      = owner_q;
   assign owner_lock_o = olock_q;

   AST_OWNER_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_i |=> $stable(owner_o)) else $error("owner moved without ready"); // R2
   AST_GRANT_HELD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready_i && resp_i == RSP_OKAY) |=> $stable(grant_o)) else $error("grant moved in wait"); // R13
   AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_q != DUMMY) |-> !(|(mask_q & grant_oh))) else $error("masked master granted"); // R8
   AST_PARK_ON_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
      park_q |-> (grant_q == DUMMY)) else $error("parked but not on dummy"); // R11
   AST_SETTLE_KEEPS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_i && grant_q != owner_q) |=> $stable(grant_o)) else $error("grant moved at handover"); // R5
   AST_LOCK_KEEPS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_i && grant_q == owner_q && grant_locked) |=> $stable(grant_o)) else $error("lock broken"); // R10

endmodule

// File: tb/mbus_arbiter_tb.sv
module mbus_arbiter_tb_top;

   localparam int CLK_P = 10;
   localparam int NM    = 6;
   localparam int DEFM  = 3;
   localparam logic [15:0] LIVE = 16'h003F;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NM-1:0] req = '0, lck = '0;
   logic          rdy = 1'b1;
   logic [1:0]    resp = 2'b00, trans = 2'b00;
   logic [2:0]    burst = 3'b000;
   logic [15:0]   rel = '0;
   logic [NM-1:0] grant_o;
   logic [3:0]    owner_o;
   logic          lock_o;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   mbus_arbiter #(.NUM_MASTERS(NM), .DEFAULT_MASTER(DEFM)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lck), .ready_i(rdy),
      .resp_i(resp), .trans_i(trans), .burst_i(burst), .split_release_i(rel),
      .grant_o(grant_o), .owner_o(owner_o), .owner_lock_o(lock_o));

   // behavioural reference state
   int m_g = DEFM, m_o = DEFM, m_dow = 0, m_rem = 0, m_pidx = 0;
   bit m_ol = 0, m_dl = 0, m_park = 0;
   logic [15:0] m_mask = '0;

   int  t_first, t_spl, t_nrem, t_ng, t_beats, t_pick;
   bit  t_settle, t_hold, t_keep, t_any;
   logic [15:0] t_nm;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_g = DEFM; m_o = DEFM; m_dow = 0; m_rem = 0; m_pidx = 0;
         m_ol = 0; m_dl = 0; m_park = 0; m_mask = '0;
      end else begin
         t_first = (resp != 2'b00 && !rdy) ? 1 : 0;
         t_spl   = (t_first == 1 && resp == 2'b11 && m_dow != 0) ? 1 : 0;
         t_nm    = m_mask & ~rel & 16'hFFFE & LIVE;
         if (t_spl == 1) t_nm[m_dow] = 1'b1;
         if (t_spl == 1 && m_dl) begin m_park = 1; m_pidx = m_dow; end
         else if (m_park && !t_nm[m_pidx]) m_park = 0;
         case (burst)
            3'd2, 3'd3: t_beats = 4;
            3'd4, 3'd5: t_beats = 8;
            3'd6, 3'd7: t_beats = 16;
            default:    t_beats = 0;
         endcase
         t_nrem = m_rem;
         if (t_first == 1) t_nrem = 0;
         else if (rdy) begin
            if (trans == 2'b10)      t_nrem = (t_beats > 0) ? t_beats - 1 : 0;
            else if (trans == 2'b11) t_nrem = (m_rem > 0) ? m_rem - 1 : 0;
            else if (trans == 2'b00) t_nrem = 0;
         end
         t_ng = m_g;
         if (rdy || t_first == 1) begin
            t_settle = rdy && (m_g != m_o);
            t_hold   = rdy && (t_nrem >= 2) && !t_nm[m_o];
            t_keep   = (m_g != 0) && lck[m_g] && !t_nm[m_g];
            t_pick   = -1;
            t_any    = 0;
            for (int i = NM - 1; i >= 1; i--) begin
               if (req[i]) t_any = 1;
               if (req[i] && !t_nm[i]) t_pick = i;
            end
            if (m_park)              t_ng = 0;
            else if (t_settle)       t_ng = m_g;
            else if (t_hold)         t_ng = m_o;
            else if (t_keep)         t_ng = m_g;
            else if (t_pick >= 0)    t_ng = t_pick;
            else if (t_any)          t_ng = 0;
            else if (t_nm[DEFM])     t_ng = 0;
            else                     t_ng = DEFM;
         end
         if (rdy) begin
            m_dl  = m_ol;
            m_dow = m_o;
            m_ol  = (m_g != 0) && lck[m_g];
            m_o   = m_g;
         end
         m_g    = t_ng;
         m_rem  = t_nrem;
         m_mask = t_nm;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cmp_model();
      check("R3 grant vs model", int'(grant_o), 1 << m_g);
      check("R2 owner vs model", int'(owner_o), m_o);
      check("R10 lock vs model", int'(lock_o), int'(m_ol));
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      cmp_model();
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset grant", int'(grant_o), 1 << DEFM);
      check("R1 reset owner", int'(owner_o), DEFM);
      check("R1 reset lock", int'(lock_o), 0);

      step(); check("R4 idle to default", int'(grant_o), 1 << DEFM);
      req = 6'b000001;
      step(); check("R3 slot0 request ignored", int'(grant_o), 1 << DEFM);
      req = 6'b010100;
      step(); check("R3 lowest wins", int'(grant_o), 1 << 2);
      step(); check("R2 ownership on ready", int'(owner_o), 2);

      // fixed 4-beat burst by master 2, which drops its request
      req = 6'b010000; trans = 2'b10; burst = 3'b011;
      step(); check("R6 hold after NONSEQ", int'(grant_o), 1 << 2);
      trans = 2'b11;
      step(); check("R6 hold mid burst", int'(grant_o), 1 << 2);
      step(); check("R6 release before last beat", int'(grant_o), 1 << 4);
      check("R6 owner still burst master", int'(owner_o), 2);
      req = 6'b010010;
      step(); check("R5 no re-evaluation at handover", int'(grant_o), 1 << 4);
      check("R5 owner took grant", int'(owner_o), 4);
      trans = 2'b00; burst = 3'b000; req = 6'b010000;
      step();

      // split of master 4
      req = 6'b110000; trans = 2'b10;
      step(); check("R3 master 4 keeps", int'(grant_o), 1 << 4);
      rdy = 1'b0; resp = 2'b11; trans = 2'b00;
      step(); check("R7 grant moves in first split cycle", int'(grant_o), 1 << 5);
      check("R2 owner frozen while not ready", int'(owner_o), 4);
      rdy = 1'b1;
      step(); check("R2 owner follows grant", int'(owner_o), 5);
      resp = 2'b00;
      step(); check("R8 masked master not granted", int'(grant_o), 1 << 5);
      req = 6'b010000;
      step(); check("R9 all requesters split to dummy", int'(grant_o), 1);
      rel = 16'h0010;
      step(); check("R8 settle on dummy", int'(grant_o), 1);
      rel = 16'h0000;
      step(); check("R8 readmitted after release", int'(grant_o), 1 << 4);

      // locked sequence split
      req = 6'b010010; lck = 6'b010000;
      step(); check("R10 lock flag for owner", int'(lock_o), 1);
      step(); check("R10 locked master keeps grant", int'(grant_o), 1 << 4);
      rdy = 1'b0; resp = 2'b11;
      step(); check("R11 locked split parks on dummy", int'(grant_o), 1);
      rdy = 1'b1; lck = '0;
      step();
      resp = 2'b00;
      step(); check("R11 parked despite request", int'(grant_o), 1);
      rel = 16'h0010;
      step(); check("R11 unpark on release", int'(grant_o), 1 << 1);
      rel = 16'h0000;

      // retry
      req = 6'b000110; trans = 2'b10;
      step();
      step();
      rdy = 1'b0; resp = 2'b10; trans = 2'b00;
      step(); check("R12 retry keeps priority", int'(grant_o), 1 << 1);
      rdy = 1'b1;
      step(); check("R12 retry no mask", int'(grant_o), 1 << 1);
      resp = 2'b00;

      // wait states
      req = 6'b000100; rdy = 1'b0;
      step(); check("R13 grant frozen in wait", int'(grant_o), 1 << 1);
      step(); check("R13 grant frozen second wait", int'(grant_o), 1 << 1);
      rdy = 1'b1;
      step(); check("R13 re-evaluate on ready", int'(grant_o), 1 << 2);

      // random traffic against the model
      for (int k = 0; k < 6000; k++) begin
         req   = NM'($urandom);
         lck   = NM'($urandom & $urandom & $urandom);
         rdy   = ($urandom % 4) != 0;
         resp  = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
         trans = 2'($urandom);
         burst = 3'($urandom);
         rel   = (($urandom % 5) == 0) ? 16'($urandom) : 16'h0000;
         step();
      end

      summary();
      $finish;
   end

endmodule